// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block is the shift and rotate unit of a processor datapath. It takes a data word, an unsigned shift amount and an operation code, and it returns the shifted or rotated word together with the next value of the carry flag. Three operations are supported: logical left shift, logical right shift and rotate right. A fourth code passes the word through unchanged. The shift amount is wider than the word index, so amounts of zero, of exactly the word width and of more than the word width all have defined results.

The carry rules depend on the operation. A zero amount never disturbs the flag. A normal amount loads the flag with the last bit that left the word. A logical shift by more than the word width clears the flag. When the caller's carry-update enable is low, the incoming flag passes straight through. An optional output register stage, selected by a parameter and enabled by default, gives the unit one cycle of latency so it can sit on a timing-critical path.

Top module: `barrel_shift_unit`

## Requirements
- R1: Operation code 2'b00 (logical left) by n in 1..31 returns the operand moved n places toward bit 31, with the low n result bits zero.
- R2: For logical left with carry update enabled and n in 1..32, the carry output is operand bit[32-n], so n = 32 gives bit 0.
- R3: Operation code 2'b01 (logical right) by n in 1..31 fills the high n result bits with zeros. With carry update enabled and n in 1..32 the carry is operand bit[n-1], so n = 32 gives bit 31.
- R4: Both logical shifts with an amount of 32 or more return an all-zero result.
- R5: Both logical shifts with an amount of 33 or more and carry update enabled return a carry of 0.
- R6: Operation code 2'b10 (rotate right) returns the operand rotated right by the amount modulo 32. An amount that is a non-zero multiple of 32 returns the operand unchanged.
- R7: For rotate right with carry update enabled and a non-zero amount n, the carry is operand bit[(n-1) mod 32]. A non-zero multiple of 32 therefore gives bit 31.
- R8: An amount of zero returns the operand unchanged and the incoming carry, for every operation and whatever the carry-update enable is.
- R9: With the carry-update enable low, the carry output equals the incoming carry for every operation and amount.
- R10: Operation code 2'b11 returns the operand unchanged and the incoming carry.
- R11: With the output stage enabled (the default), results appear one clock after the inputs are applied. An active-low reset clears the result and the carry output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset of the output stage |
| operand_i | input | 32 | Data word to shift or rotate |
| amount_i | input | 8 | Unsigned shift or rotate amount |
| op_i | input | 2 | 00 left logical, 01 right logical, 10 rotate right, 11 pass |
| upd_carry_i | input | 1 | When high, the carry may be replaced by a shifted-out bit |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted or rotated word |
| carry_o | output | 1 | Next carry flag |

## Verification
The unit holds no state apart from the output register, so any internal error shows at the ports on the cycle after the faulty inputs are applied. A wrong stage distance or select bit corrupts the result only for amounts with that bit set. For this reason the vectors pair each power-of-two amount with amounts at the edges: 0, 1, 31, 32, 33 and 255. A wrong carry index or a wrong large-amount decode shows as a flipped carry, and only at the boundary amounts where the rules change. Those are the exact cases the directed vectors cover.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

   typedef enum logic [1:0] {
      OP_LSL  = 2'b00,
      OP_LSR  = 2'b01,
      OP_ROR  = 2'b10,
      OP_PASS = 2'b11
   } shop_e;

   localparam int DIR_LEFT  = 0;
   localparam int DIR_RIGHT = 1;
   localparam int DIR_ROTR  = 2;

endpackage

// File: rtl/bshift_stage.sv
module bshift_stage #(
   parameter int W    = 32,
   parameter int DIST = 1,
   parameter int DIR  = bshift_pkg::DIR_LEFT
) (
   input  logic [W-1:0] d_i,
   input  logic         sel_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] moved;

   generate
      if (DIST < 1 || DIST >= W) begin : g_bad
         $error("bshift_stage: DIST must lie in 1..W-1");
      end
      if (DIR == bshift_pkg::DIR_LEFT) begin : g_left
         assign moved = {d_i[W-DIST-1:0], {DIST{1'b0}}};
      end else if (DIR == bshift_pkg::DIR_RIGHT) begin : g_right
         assign moved = {{DIST{1'b0}}, d_i[W-1:DIST]};
      end else begin : g_rotr
         assign moved = {d_i[DIST-1:0], d_i[W-1:DIST]};
      end
   endgenerate

   assign q_o = sel_i ? moved : d_i;

endmodule

// File: rtl/bshift_core.sv
module bshift_core #(
   parameter int W     = 32,
   parameter int AMT_W = 8
) (
   input  logic [W-1:0]         operand_i,
   input  logic [AMT_W-1:0]     amount_i,
   input  bshift_pkg::shop_e    op_i,
   output logic [W-1:0]         result_o
);
   import bshift_pkg::*;

   localparam int LOG = $clog2(W);

   logic [W-1:0] l_chain [0:LOG];
   logic [W-1:0] r_chain [0:LOG];
   logic [W-1:0] o_chain [0:LOG];
   logic         too_far;

   assign l_chain[0] = operand_i;
   assign r_chain[0] = operand_i;
   assign o_chain[0] = operand_i;

   generate
      for (genvar s = 0; s < LOG; s++) begin : g_stage
         bshift_stage #(.W(W), .DIST(1 << s), .DIR(DIR_LEFT)) u_l (
            .d_i(l_chain[s]), .sel_i(amount_i[s]), .q_o(l_chain[s+1]));
         bshift_stage #(.W(W), .DIST(1 << s), .DIR(DIR_RIGHT)) u_r (
            .d_i(r_chain[s]), .sel_i(amount_i[s]), .q_o(r_chain[s+1]));
         bshift_stage #(.W(W), .DIST(1 << s), .DIR(DIR_ROTR)) u_o (
            .d_i(o_chain[s]), .sel_i(amount_i[s]), .q_o(o_chain[s+1]));
      end
   endgenerate

   // any amount bit at or above the word index width means amount >= W
   assign too_far = |amount_i[AMT_W-1:LOG];

   always_comb begin
      unique case (op_i)
         OP_LSL:  result_o = too_far ? '0 : l_chain[LOG];
         OP_LSR:  result_o = too_far ? '0 : r_chain[LOG];
         OP_ROR:  result_o = o_chain[LOG];
         default: result_o = operand_i;
      endcase
   end

endmodule

// File: rtl/bshift_carry.sv
module bshift_carry #(
   parameter int W     = 32,
   parameter int AMT_W = 8
) (
   input  logic [W-1:0]      operand_i,
   input  logic [AMT_W-1:0]  amount_i,
   input  bshift_pkg::shop_e op_i,
   input  logic              upd_i,
   input  logic              carry_i,
   output logic              carry_o
);
   import bshift_pkg::*;

   localparam int LOG = $clog2(W);

   logic [LOG-1:0] low_amt;
   logic [LOG-1:0] left_idx;
   logic [LOG-1:0] right_idx;
   logic           zero_amt;
   logic           beyond;

   assign low_amt   = amount_i[LOG-1:0];
   assign left_idx  = LOG'(-low_amt);          // W - n, wraps to 0 for n = W
   assign right_idx = low_amt - LOG'(1);       // n - 1 modulo W
   assign zero_amt  = (amount_i == '0);
   assign beyond    = (amount_i > AMT_W'(W));

   always_comb begin
      carry_o = carry_i;
      if (upd_i && !zero_amt) begin
         unique case (op_i)
            OP_LSL:  carry_o = beyond ? 1'b0 : operand_i[left_idx];
            OP_LSR:  carry_o = beyond ? 1'b0 : operand_i[right_idx];
            OP_ROR:  carry_o = operand_i[right_idx];
            default: carry_o = carry_i;
         endcase
      end
   end

endmodule

// File: rtl/bshift_oreg.sv
module bshift_oreg #(
   parameter int W   = 32,
   parameter bit REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] res_i,
   input  logic         c_i,
   output logic [W-1:0] res_o,
   output logic         c_o
);

   generate
      if (REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               res_o <= '0;
               c_o   <= 1'b0;
            end else begin
               res_o <= res_i;
               c_o   <= c_i;
            end
         end
      end else begin : g_wire
         assign res_o = res_i;
         assign c_o   = c_i;
      end
   endgenerate

endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit #(
   parameter int DATA_W  = 32,
   parameter int AMT_W   = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] operand_i,
   input  logic [AMT_W-1:0]  amount_i,
   input  logic [1:0]        op_i,
   input  logic              upd_carry_i,
   input  logic              carry_i,
   output logic [DATA_W-1:0] result_o,
   output logic              carry_o
);
   import bshift_pkg::*;

   localparam int LOG = $clog2(DATA_W);

   generate
      if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_chk_w
         $error("barrel_shift_unit: DATA_W must be a power of two");
      end
      if (AMT_W <= LOG) begin : g_chk_a
         $error("barrel_shift_unit: AMT_W must exceed log2(DATA_W)");
      end
   endgenerate

   shop_e             op;
   logic [DATA_W-1:0] res_c;
   logic              carry_c;

   assign op = shop_e'(op_i);

   bshift_core #(.W(DATA_W), .AMT_W(AMT_W)) u_core (
      .operand_i(operand_i),
      .amount_i (amount_i),
      .op_i     (op),
      .result_o (res_c)
   );

   bshift_carry #(.W(DATA_W), .AMT_W(AMT_W)) u_carry (
      .operand_i(operand_i),
      .amount_i (amount_i),
      .op_i     (op),
      .upd_i    (upd_carry_i),
      .carry_i  (carry_i),
      .carry_o  (carry_c)
   );

   bshift_oreg #(.W(DATA_W), .REG(OUT_REG)) u_oreg (
      .clk  (clk),
      .rst_n(rst_n),
      .res_i(res_c),
      .c_i  (carry_c),
      .res_o(result_o),
      .c_o  (carry_o)
   );

   // R4
   logical_big_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((op == OP_LSL || op == OP_LSR) && amount_i >= AMT_W'(DATA_W)) |-> (res_c == '0));

   // R5
   logical_far_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((op == OP_LSL || op == OP_LSR) && upd_carry_i && amount_i > AMT_W'(DATA_W))
      |-> (carry_c == 1'b0));

   // R6
   ror_full_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_ROR && amount_i[LOG-1:0] == '0) |-> (res_c == operand_i));

   // R8
   zero_amount_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (amount_i == '0) |-> (res_c == operand_i && carry_c == carry_i));

   // R9
   carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_carry_i) |-> (carry_c == carry_i));

   // R10
   pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_PASS) |-> (res_c == operand_i && carry_c == carry_i));

endmodule

// File: tb/barrel_shift_unit_bench.sv
module barrel_shift_unit_bench;

   typedef struct packed {
      logic [1:0]  op;
      logic [7:0]  amt;
      logic [31:0] a;
      logic        upd;
      logic        cin;
      logic [31:0] exp_r;
      logic        exp_c;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VECS [NV] = '{
      '{2'b00, 8'd0,   32'h8000_0001, 1'b1, 1'b1, 32'h8000_0001, 1'b1}, // R8
      '{2'b00, 8'd1,   32'h8000_0001, 1'b1, 1'b0, 32'h0000_0002, 1'b1}, // R1 R2
      '{2'b00, 8'd31,  32'h8000_0001, 1'b1, 1'b1, 32'h8000_0000, 1'b0}, // R1 R2
      '{2'b00, 8'd32,  32'h8000_0001, 1'b1, 1'b0, 32'h0000_0000, 1'b1}, // R2 R4
      '{2'b00, 8'd33,  32'h8000_0001, 1'b1, 1'b1, 32'h0000_0000, 1'b0}, // R5
      '{2'b01, 8'd1,   32'h8000_0001, 1'b1, 1'b0, 32'h4000_0000, 1'b1}, // R3
      '{2'b01, 8'd32,  32'h8000_0001, 1'b1, 1'b0, 32'h0000_0000, 1'b1}, // R3 R4
      '{2'b01, 8'd255, 32'h8000_0001, 1'b1, 1'b1, 32'h0000_0000, 1'b0}, // R5
      '{2'b10, 8'd1,   32'h8000_0001, 1'b1, 1'b0, 32'hC000_0000, 1'b1}, // R6 R7
      '{2'b10, 8'd32,  32'h8000_0001, 1'b1, 1'b0, 32'h8000_0001, 1'b1}, // R6 R7
      '{2'b10, 8'd33,  32'h8000_0001, 1'b1, 1'b0, 32'hC000_0000, 1'b1}, // R6 R7
      '{2'b10, 8'd255, 32'h8000_0001, 1'b1, 1'b1, 32'h0000_0003, 1'b0}, // R6 R7
      '{2'b00, 8'd4,   32'hF000_0000, 1'b0, 1'b1, 32'h0000_0000, 1'b1}, // R9
      '{2'b11, 8'd5,   32'h1234_5678, 1'b1, 1'b0, 32'h1234_5678, 1'b0}, // R10
      '{2'b01, 8'd4,   32'h0000_000F, 1'b1, 1'b0, 32'h0000_0000, 1'b1}, // R3
      '{2'b10, 8'd8,   32'h1234_5678, 1'b1, 1'b1, 32'h7812_3456, 1'b0}, // R6 R7
      '{2'b00, 8'd8,   32'h1234_5678, 1'b1, 1'b1, 32'h3456_7800, 1'b0}  // R1 R2
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] operand_i = '0;
   logic [7:0]  amount_i = '0;
   logic [1:0]  op_i = '0;
   logic        upd_carry_i = 1'b0;
   logic        carry_i = 1'b0;
   logic [31:0] result_o;
   logic        carry_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   barrel_shift_unit u_barrel_shift_unit (
      .clk(clk), .rst_n(rst_n), .operand_i(operand_i), .amount_i(amount_i),
      .op_i(op_i), .upd_carry_i(upd_carry_i), .carry_i(carry_i),
      .result_o(result_o), .carry_o(carry_o)
   );

   function automatic logic [32:0] ref_model(input logic [1:0] op, input logic [7:0] amt,
                                             input logic [31:0] a, input logic upd,
                                             input logic cin);
      logic [31:0] r = a;
      logic        c = cin;
      int          n = int'(amt);
      case (op)
         2'b00: begin
            for (int i = 0; i < 32; i++) r[i] = (i >= n) ? a[i-n] : 1'b0;
            if (upd && n != 0) c = (n <= 32) ? a[32-n] : 1'b0;
         end
         2'b01: begin
            for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? a[i+n] : 1'b0;
            if (upd && n != 0) c = (n <= 32) ? a[n-1] : 1'b0;
         end
         2'b10: begin
            for (int i = 0; i < 32; i++) r[i] = a[(i + n) % 32];
            if (upd && n != 0) c = a[(n - 1) % 32];
         end
         default: ;
      endcase
      return {c, r};
   endfunction

   task automatic check(input string req, input logic [31:0] er, input logic ec);
      checks++;
      if (result_o !== er || carry_o !== ec) begin
         fails++;
         $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
                  req, result_o, carry_o, er, ec);
      end
   endtask

   task automatic apply(input logic [1:0] op, input logic [7:0] amt, input logic [31:0] a,
                        input logic upd, input logic cin);
      @(negedge clk);
      op_i = op; amount_i = amt; operand_i = a; upd_carry_i = upd; carry_i = cin;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R11 reset", 32'h0, 1'b0);
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         apply(VECS[k].op, VECS[k].amt, VECS[k].a, VECS[k].upd, VECS[k].cin);
         check($sformatf("vector %0d (R1..R10 table)", k), VECS[k].exp_r, VECS[k].exp_c);
      end

      // R11: output holds the previous result until the next clock edge
      apply(2'b00, 8'd1, 32'h0000_0001, 1'b1, 1'b0);
      @(negedge clk);
      operand_i = 32'h0000_0004;
      #1 check("R11 latency hold", 32'h0000_0002, 1'b0);
      @(negedge clk);
      check("R11 latency update", 32'h0000_0008, 1'b0);

      // R8 zero amount on each op with update enabled
      for (int o = 0; o < 4; o++) begin
         apply(2'(o), 8'd0, 32'hA5A5_0F0F, 1'b1, 1'b1);
         check("R8 zero amount", 32'hA5A5_0F0F, 1'b1);
      end

      // R1..R7 boundary amounts and random operands against the reference model
      for (int k = 0; k < 300; k++) begin
         logic [7:0]  amt;
         logic [31:0] a;
         logic [1:0]  op;
         logic        upd;
         logic        cin;
         logic [32:0] e;
         case (k % 8)
            0: amt = 8'd0;
            1: amt = 8'd1;
            2: amt = 8'd31;
            3: amt = 8'd32;
            4: amt = 8'd33;
            5: amt = 8'd255;
            default: amt = 8'($urandom_range(0, 255));
         endcase
         a   = $urandom;
         op  = 2'((k / 8) % 4);
         upd = 1'($urandom_range(0, 3) != 0);
         cin = 1'($urandom_range(0, 1));
         e   = ref_model(op, amt, a, upd, cin);
         apply(op, amt, a, upd, cin);
         check("R1-R10 random model", e[31:0], e[32]);
      end

      // R11 reset in mid run clears outputs
      apply(2'b11, 8'd3, 32'hFFFF_FFFF, 1'b1, 1'b1);
      rst_n = 1'b0;
      #1 check("R11 async reset", 32'h0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule